// File: doc/BRIEF.md
# RGB Input Gamma Lookup Stage

This block applies an input gamma curve to RGB pixels, channel by channel. Each of red, green and blue has two 256-entry tables, bank A and bank B. An 8-bit channel code addresses its table and comes out as a 12-bit unsigned fraction (u0.12). A third mode, bypass, passes the code through unchanged, zero-extended to 12 bits.

A host fills whichever bank is idle through a small write port. It chooses the target bank, clears the write pointer, then sends one word per colour. The words go red first, then green, then blue for the same entry, and the pointer moves to the next entry after blue. A 3-bit mask can skip channels. The host then writes a new mode code. That code is held as pending and becomes live at the next frame-start pulse, so a frame never mixes two tables. Meanwhile the pixel path keeps reading the bank that is live.

The live-bank tracker has three states, LIVE_NONE, LIVE_A and LIVE_B. Its only transition is "frame load", taken on frame_start, which moves to the state that the pending mode decodes to. The write sequencer has three states, SEQ_RED, SEQ_GREEN and SEQ_BLUE, and two transitions. "Advance" follows RED to GREEN to BLUE and back to RED, stepping the pointer on the BLUE to RED step. "Clear" returns it to SEQ_RED at entry 0.

Top module: `rgb_gamma_lut`

## Requirements
- R1: After reset the live state is bypass (status 0), pix_out_valid is 0, pix_in_ready is 1, and the write sequencer sits at entry 0 expecting red.
- R2: In bypass (mode code 0) each output channel equals its 8-bit input zero-extended to 12 bits.
- R3: With mode code 2 live, each output channel equals bank A's entry for that channel at the input code.
- R4: With mode code 3 live, each output channel equals bank B's entry for that channel at the input code.
- R5: A pulse on cfg_idx_clr sets the pointer to entry 0 and expects red. Each cfg_wr consumes one word, stored in the order red, green, blue, and the pointer steps after blue. It wraps from 255 to 0.
- R6: Write mask bit 0 enables red, bit 1 green and bit 2 blue. A word for a channel whose bit is clear is consumed but leaves that table unchanged.
- R7: cfg_bank_sel 0 targets bank A and 1 targets bank B. Writes aimed at the live bank store nothing, although the sequencer still advances.
- R8: A mode write only updates the pending mode, and the live table changes at the next frame_start. Mode code 1 is reserved, and a write of it leaves the pending mode unchanged.
- R9: The status output reads 0 when bypass is live, 1 when bank A is live and 2 when bank B is live.
- R10: A pixel accepted on a clock edge appears on the output two edges later. pix_in_ready equals (not pix_out_valid) or pix_out_ready. While the output is stalled it holds its valid and data.
- R11: A frame_start in the same cycle as a mode write makes live the pending mode from before that write. The new code waits for the following frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bank_sel | input | 1 | Target bank for host writes (0 = A, 1 = B) |
| cfg_idx_clr | input | 1 | Clear write pointer to entry 0, red |
| cfg_wmask | input | 3 | Per-channel write enable (bit0 R, bit1 G, bit2 B) |
| cfg_wr | input | 1 | Host data word strobe |
| cfg_wdata | input | OUT_W | Host data word (u0.12) |
| cfg_mode_wr | input | 1 | Mode write strobe |
| cfg_mode | input | 2 | Mode code: 0 bypass, 2 bank A, 3 bank B |
| frame_start | input | 1 | Frame boundary pulse; loads pending mode |
| lut_status | output | 3 | Live table: 0 bypass, 1 A, 2 B |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_in_ready | output | 1 | Input pixel accepted when high |
| pix_in_r | input | IN_W | Red code |
| pix_in_g | input | IN_W | Green code |
| pix_in_b | input | IN_W | Blue code |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out_ready | input | 1 | Downstream ready |
| pix_out_r | output | OUT_W | Red result |
| pix_out_g | output | OUT_W | Green result |
| pix_out_b | output | OUT_W | Blue result |

## Verification
A pixel accepted on an edge produces its output after the second edge that follows. The bench samples at the falling edge after that second edge and also checks that nothing is valid one edge earlier. A host data word lands in its RAM at the edge it is strobed. A mode write never changes the status on its own. Status only moves at the edge that samples frame_start, so the bench reads status half a cycle after the mode write and again half a cycle after the frame pulse. The stall check holds pix_out_ready low for several cycles and compares the held output on each falling edge.

// File: rtl/rgb_gamma_pkg.sv
package rgb_gamma_pkg;
    localparam int CH_N = 3;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_RSVD   = 2'd1,
        MODE_BANK_A = 2'd2,
        MODE_BANK_B = 2'd3
    } lut_mode_e;

    typedef enum logic [1:0] {
        SEQ_RED   = 2'd0,
        SEQ_GREEN = 2'd1,
        SEQ_BLUE  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        LIVE_NONE = 2'd0,
        LIVE_A    = 2'd1,
        LIVE_B    = 2'd2
    } live_state_e;
endpackage

// File: rtl/rgb_gamma_lut_ram.sv
// One channel table: single write port, registered read port.
module rgb_gamma_lut_ram #(
    parameter int AW = 8,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/rgb_gamma_host_seq.sv
// Host write sequencer: red, green, blue per entry, pointer steps after blue.
module rgb_gamma_host_seq
    import rgb_gamma_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idx_clr,
    input  logic            wr,
    input  logic            bank_sel,
    input  logic [CH_N-1:0] wmask,
    input  logic            live_a,
    input  logic            live_b,
    output logic [CH_N-1:0] we_a,
    output logic [CH_N-1:0] we_b,
    output logic [AW-1:0]   waddr
);
    seq_state_e    state_q, state_d;
    logic [AW-1:0] idx_q, idx_d;
    logic [CH_N-1:0] ch_oh;
    logic          target_live;
    logic [CH_N-1:0] we_any;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_RED;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // transitions: clear, advance
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (idx_clr) begin
            state_d = SEQ_RED;
            idx_d   = '0;
        end else if (wr) begin
            unique case (state_q)
                SEQ_RED:   state_d = SEQ_GREEN;
                SEQ_GREEN: state_d = SEQ_BLUE;
                SEQ_BLUE: begin
                    state_d = SEQ_RED;
                    idx_d   = idx_q + 1'b1;
                end
                default:   state_d = SEQ_RED;
            endcase
        end
    end

    // outputs
    always_comb begin
        ch_oh = '0;
        unique case (state_q)
            SEQ_RED:   ch_oh[0] = 1'b1;
            SEQ_GREEN: ch_oh[1] = 1'b1;
            SEQ_BLUE:  ch_oh[2] = 1'b1;
            default:   ch_oh = '0;
        endcase
        target_live = bank_sel ? live_b : live_a;
        we_any = (wr && !idx_clr && !target_live) ? (ch_oh & wmask) : '0;
        we_a   = bank_sel ? '0 : we_any;
        we_b   = bank_sel ? we_any : '0;
        waddr  = idx_q;
    end

    // R5: pointer steps by one (with wrap) after the blue word
    a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !idx_clr && state_q == SEQ_BLUE) |=> (idx_q == AW'($past(idx_q) + 1'b1)));

    // R5: clear returns to entry 0, red
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        idx_clr |=> (idx_q == '0 && state_q == SEQ_RED));

    // R5: at most one channel written per word
    a_r5_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_a, we_b}));
endmodule

// File: rtl/rgb_gamma_mode_ctrl.sv
// Pending mode register and frame-synchronous live-bank tracker.
module rgb_gamma_mode_ctrl
    import rgb_gamma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [1:0] mode_code,
    input  logic       frame_start,
    output lut_mode_e  active_mode,
    output logic       live_a,
    output logic       live_b,
    output logic [2:0] status
);
    lut_mode_e   pending_q;
    live_state_e live_q, live_d;

    always_ff @(posedge clk) begin
        if (!rst_n) pending_q <= MODE_BYPASS;
        else if (mode_wr && lut_mode_e'(mode_code) != MODE_RSVD)
            pending_q <= lut_mode_e'(mode_code);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= LIVE_NONE;
        else        live_q <= live_d;
    end

    // transition: frame load
    always_comb begin
        live_d = live_q;
        if (frame_start) begin
            unique case (pending_q)
                MODE_BYPASS: live_d = LIVE_NONE;
                MODE_BANK_A: live_d = LIVE_A;
                MODE_BANK_B: live_d = LIVE_B;
                default:     live_d = live_q;
            endcase
        end
    end

    // outputs
    always_comb begin
        active_mode = MODE_BYPASS;
        live_a      = 1'b0;
        live_b      = 1'b0;
        status      = 3'd0;
        unique case (live_q)
            LIVE_NONE: status = 3'd0;
            LIVE_A: begin
                active_mode = MODE_BANK_A;
                live_a      = 1'b1;
                status      = 3'd1;
            end
            LIVE_B: begin
                active_mode = MODE_BANK_B;
                live_b      = 1'b1;
                status      = 3'd2;
            end
            default: status = 3'd0;
        endcase
    end

    // R8: live table moves only on a frame pulse
    a_r8_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(live_q));

    // R8: reserved code leaves the pending mode alone
    a_r8_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_code == 2'd1) |=> $stable(pending_q));

    // R9: never both banks live
    a_r9_one_live: assert property (@(posedge clk) disable iff (!rst_n)
        !(live_a && live_b));
endmodule

// File: rtl/rgb_gamma_lut.sv
module rgb_gamma_lut
    import rgb_gamma_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_bank_sel,
    input  logic             cfg_idx_clr,
    input  logic [2:0]       cfg_wmask,
    input  logic             cfg_wr,
    input  logic [OUT_W-1:0] cfg_wdata,
    input  logic             cfg_mode_wr,
    input  logic [1:0]       cfg_mode,
    input  logic             frame_start,
    output logic [2:0]       lut_status,
    input  logic             pix_in_valid,
    output logic             pix_in_ready,
    input  logic [IN_W-1:0]  pix_in_r,
    input  logic [IN_W-1:0]  pix_in_g,
    input  logic [IN_W-1:0]  pix_in_b,
    output logic             pix_out_valid,
    input  logic             pix_out_ready,
    output logic [OUT_W-1:0] pix_out_r,
    output logic [OUT_W-1:0] pix_out_g,
    output logic [OUT_W-1:0] pix_out_b
);
    localparam int PAD_W = OUT_W - IN_W;

    lut_mode_e active_mode;
    logic      live_a, live_b;
    logic [CH_N-1:0] we_a, we_b;
    logic [IN_W-1:0] waddr;

    logic pipe_en;
    logic v1_q, v2_q;
    lut_mode_e mode1_q, mode2_q;
    logic [CH_N-1:0][IN_W-1:0]  pix_in, pix1_q, pix2_q;
    logic [CH_N-1:0][OUT_W-1:0] rd_a, rd_b, pix_out;

    rgb_gamma_mode_ctrl u_mode (
        .clk(clk), .rst_n(rst_n), .mode_wr(cfg_mode_wr), .mode_code(cfg_mode),
        .frame_start(frame_start), .active_mode(active_mode),
        .live_a(live_a), .live_b(live_b), .status(lut_status)
    );

    rgb_gamma_host_seq #(.AW(IN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .idx_clr(cfg_idx_clr), .wr(cfg_wr),
        .bank_sel(cfg_bank_sel), .wmask(cfg_wmask), .live_a(live_a), .live_b(live_b),
        .we_a(we_a), .we_b(we_b), .waddr(waddr)
    );

    assign pix_in       = {pix_in_b, pix_in_g, pix_in_r};
    assign pipe_en      = !v2_q || pix_out_ready;
    assign pix_in_ready = pipe_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q    <= 1'b0;
            v2_q    <= 1'b0;
            mode1_q <= MODE_BYPASS;
            mode2_q <= MODE_BYPASS;
            pix1_q  <= '0;
            pix2_q  <= '0;
        end else if (pipe_en) begin
            v1_q    <= pix_in_valid;
            pix1_q  <= pix_in;
            mode1_q <= active_mode;
            v2_q    <= v1_q;
            pix2_q  <= pix1_q;
            mode2_q <= mode1_q;
        end
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        rgb_gamma_lut_ram #(.AW(IN_W), .DW(OUT_W)) u_ram_a (
            .clk(clk), .we(we_a[c]), .waddr(waddr), .wdata(cfg_wdata),
            .re(pipe_en), .raddr(pix1_q[c]), .rdata(rd_a[c])
        );
        rgb_gamma_lut_ram #(.AW(IN_W), .DW(OUT_W)) u_ram_b (
            .clk(clk), .we(we_b[c]), .waddr(waddr), .wdata(cfg_wdata),
            .re(pipe_en), .raddr(pix1_q[c]), .rdata(rd_b[c])
        );
        always_comb begin
            unique case (mode2_q)
                MODE_BANK_A: pix_out[c] = rd_a[c];
                MODE_BANK_B: pix_out[c] = rd_b[c];
                default:     pix_out[c] = {{PAD_W{1'b0}}, pix2_q[c]};
            endcase
        end
    end

    assign pix_out_valid = v2_q;
    assign pix_out_r     = pix_out[0];
    assign pix_out_g     = pix_out[1];
    assign pix_out_b     = pix_out[2];

    // R7: no table of the live bank is ever written
    a_r7_live_guard: assert property (@(posedge clk) disable iff (!rst_n)
        !((|we_a) && live_a) && !((|we_b) && live_b));

    // R10: stalled output holds valid and data
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_out_valid && !pix_out_ready) |=>
            (pix_out_valid && $stable(pix_out_r) && $stable(pix_out_g) && $stable(pix_out_b)));

    // R10: two-stage valid path
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_in_valid && pix_in_ready && pix_out_ready) |=> v1_q);
endmodule

// File: tb/rgb_gamma_lut_test.sv
module rgb_gamma_lut_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam logic [23:0] VEC [NV] = '{
        24'h000000, 24'hFFFFFF, 24'h0180FF, 24'h7F8081,
        24'h123456, 24'hA5C30F, 24'hFE0102, 24'h55AA33
    };

    logic clk = 0;
    logic rst_n = 0;
    logic cfg_bank_sel = 0, cfg_idx_clr = 0, cfg_wr = 0, cfg_mode_wr = 0, frame_start = 0;
    logic [2:0] cfg_wmask = 3'b111;
    logic [11:0] cfg_wdata = 0;
    logic [1:0] cfg_mode = 0;
    logic [2:0] lut_status;
    logic pix_in_valid = 0, pix_in_ready, pix_out_valid, pix_out_ready = 1;
    logic [7:0] pix_in_r = 0, pix_in_g = 0, pix_in_b = 0;
    logic [11:0] pix_out_r, pix_out_g, pix_out_b;

    int n_chk = 0;
    int n_bad = 0;
    int mdl_a [3][256];
    int mdl_b [3][256];

    always #(CLK_PERIOD/2) clk = ~clk;

    rgb_gamma_lut uut (
        .clk(clk), .rst_n(rst_n), .cfg_bank_sel(cfg_bank_sel), .cfg_idx_clr(cfg_idx_clr),
        .cfg_wmask(cfg_wmask), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_mode_wr(cfg_mode_wr), .cfg_mode(cfg_mode), .frame_start(frame_start),
        .lut_status(lut_status), .pix_in_valid(pix_in_valid), .pix_in_ready(pix_in_ready),
        .pix_in_r(pix_in_r), .pix_in_g(pix_in_g), .pix_in_b(pix_in_b),
        .pix_out_valid(pix_out_valid), .pix_out_ready(pix_out_ready),
        .pix_out_r(pix_out_r), .pix_out_g(pix_out_g), .pix_out_b(pix_out_b)
    );

    function automatic int fa(int ch, int e);
        return (e * 13 + ch * 1000 + 7) & 12'hFFF;
    endfunction
    function automatic int fb(int ch, int e);
        return (4095 - e * 11 - ch * 300) & 12'hFFF;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // all host and pixel tasks start and end at a falling edge
    task automatic hw(input int d);
        cfg_wr = 1; cfg_wdata = 12'(d);
        @(negedge clk); cfg_wr = 0;
    endtask
    task automatic clr_idx();
        cfg_idx_clr = 1; @(negedge clk); cfg_idx_clr = 0;
    endtask
    task automatic set_mode(input int m);
        cfg_mode_wr = 1; cfg_mode = 2'(m); @(negedge clk); cfg_mode_wr = 0;
    endtask
    task automatic frame();
        frame_start = 1; @(negedge clk); frame_start = 0;
    endtask

    task automatic send_px(input int r, input int g, input int b,
                           output int orr, output int og, output int ob);
        pix_in_valid = 1; pix_in_r = 8'(r); pix_in_g = 8'(g); pix_in_b = 8'(b);
        @(posedge clk); @(negedge clk); pix_in_valid = 0;
        check("R10", "valid one edge after accept", pix_out_valid, 0);
        @(posedge clk); @(negedge clk);
        check("R10", "valid two edges after accept", pix_out_valid, 1);
        orr = pix_out_r; og = pix_out_g; ob = pix_out_b;
    endtask

    task automatic run_vectors(input int mode, input string req);
        for (int i = 0; i < NV; i++) begin
            int r, g, b, orr, og, ob, er, eg, eb;
            r = VEC[i][23:16]; g = VEC[i][15:8]; b = VEC[i][7:0];
            send_px(r, g, b, orr, og, ob);
            if (mode == 2) begin er = mdl_a[0][r]; eg = mdl_a[1][g]; eb = mdl_a[2][b]; end
            else if (mode == 3) begin er = mdl_b[0][r]; eg = mdl_b[1][g]; eb = mdl_b[2][b]; end
            else begin er = r; eg = g; eb = b; end
            check(req, "red", orr, er);
            check(req, "green", og, eg);
            check(req, "blue", ob, eb);
        end
    endtask

    task automatic load_bank(input int bank);
        cfg_bank_sel = 1'(bank); cfg_wmask = 3'b111;
        clr_idx();
        for (int e = 0; e < 256; e++)
            for (int c = 0; c < 3; c++)
                hw(bank == 0 ? mdl_a[c][e] : mdl_b[c][e]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int orr, og, ob;
        for (int c = 0; c < 3; c++)
            for (int e = 0; e < 256; e++) begin
                mdl_a[c][e] = fa(c, e);
                mdl_b[c][e] = fb(c, e);
            end

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        check("R1", "status after reset", lut_status, 0);
        check("R1", "out_valid after reset", pix_out_valid, 0);
        check("R1", "in_ready after reset", pix_in_ready, 1);

        // R2 bypass table
        run_vectors(0, "R2");

        // R1/R5: pointer starts at entry 0, red, with no clear
        cfg_bank_sel = 0;
        hw(12'h111); hw(12'h222); hw(12'h333);
        set_mode(2);
        check("R8", "status before frame pulse", lut_status, 0);
        frame();
        check("R9", "status with bank A live", lut_status, 1);
        send_px(0, 0, 0, orr, og, ob);
        check("R1", "first word to red entry 0", orr, 12'h111);
        check("R5", "second word to green", og, 12'h222);
        check("R5", "third word to blue", ob, 12'h333);
        set_mode(0); frame();
        check("R9", "status back to bypass", lut_status, 0);

        // R3 full bank A
        load_bank(0);
        set_mode(2); frame();
        run_vectors(2, "R3");

        // R7: writes to the live bank are dropped
        cfg_bank_sel = 0; clr_idx();
        hw(0); hw(0); hw(0);
        send_px(0, 0, 0, orr, og, ob);
        check("R7", "live bank red kept", orr, mdl_a[0][0]);
        check("R7", "live bank blue kept", ob, mdl_a[2][0]);

        // R4 full bank B
        load_bank(1);
        set_mode(3); frame();
        check("R9", "status with bank B live", lut_status, 2);
        run_vectors(3, "R4");

        // R5 wrap and R6 mask on idle bank A
        load_bank(0);
        cfg_wmask = 3'b101;
        hw(12'hABC); hw(12'hDEF); hw(12'h123);
        mdl_a[0][0] = 12'hABC; mdl_a[2][0] = 12'h123;
        cfg_wmask = 3'b111;
        set_mode(2); frame();
        send_px(0, 0, 0, orr, og, ob);
        check("R5", "wrap to entry 0 red", orr, 12'hABC);
        check("R6", "masked green unchanged", og, mdl_a[1][0]);
        check("R6", "unmasked blue stored", ob, 12'h123);
        send_px(1, 1, 1, orr, og, ob);
        check("R5", "entry 1 untouched after wrap", og, mdl_a[1][1]);

        // R11: mode write and frame pulse in one cycle
        cfg_mode_wr = 1; cfg_mode = 0; frame_start = 1;
        @(negedge clk); cfg_mode_wr = 0; frame_start = 0;
        check("R11", "old pending made live", lut_status, 1);
        frame();
        check("R11", "new code live next frame", lut_status, 0);

        // R8: reserved code ignored
        set_mode(2); set_mode(1); frame();
        check("R8", "reserved code ignored", lut_status, 1);

        // R10 stall
        pix_out_ready = 0;
        pix_in_valid = 1; pix_in_r = 8'd5; pix_in_g = 8'd6; pix_in_b = 8'd7;
        @(posedge clk); @(negedge clk); pix_in_valid = 0;
        @(posedge clk); @(negedge clk);
        check("R10", "valid under stall", pix_out_valid, 1);
        check("R10", "in_ready low under stall", pix_in_ready, 0);
        repeat (3) begin
            @(negedge clk);
            check("R10", "held valid", pix_out_valid, 1);
            check("R10", "held red", pix_out_r, mdl_a[0][5]);
            check("R10", "held blue", pix_out_b, mdl_a[2][7]);
        end
        pix_out_ready = 1;
        @(negedge clk);
        check("R10", "drained after ready", pix_out_valid, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule